// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the configuration step of a vector instruction set extension. Each configuration request supplies three things: a type word, a requested element count, and a mode that chooses where the granted length comes from. The unit decodes the type word into an element width and a register-group multiplier, and from those derives the largest length the hardware supports, a mask length and a register-group alignment mask. When the type word cannot be supported, the unit marks it illegal. It then computes the granted vector length and holds all of this as architectural state until the next request.

A request is a one-cycle strobe, and all results are registered. The granted length and every configuration register show the new values after the clock edge that samples the strobe. The decode is repeated only when the incoming type word differs from the stored one. An unsupported type collapses the maximum length to zero and replaces the stored type with a word that has only its top bit set.

Top module: `vcfg_unit`

## Requirements
- R1: Type bits [4:2] hold a code c and the element width `sew` becomes 8 << c. Type bits [1:0] hold a code m and the multiplier `lmul` becomes 1 << m. The mask length `mlen` becomes sew / lmul. `reg_mask` becomes (NVREG-1) with its low (lmul-1) bits cleared.
- R2: For a supported type, `vlmax` = VLEN * lmul / sew.
- R3: A type is unsupported when sew > ELEN, when bits [6:5] are not zero, or when any bit at position 7 or above is set. After such a request, `illegal` is 1, `vlmax` is 0 and `vtype` holds only bit XLEN-1.
- R4: Mode 0 grants min(req_len, vlmax).
- R5: Mode 1 grants min(previous vl, vlmax), and `req_len` has no effect.
- R6: Mode 2 grants `vlmax` whatever `req_len` is. Mode 3 behaves as mode 0.
- R7: When the resulting `vlmax` is 0, the granted `vl` is 0 in every mode.
- R8: Every request leaves `vstart` at 0. All outputs take their new values at the clock edge that samples `cfg_valid`.
- R9: While `cfg_valid` is low, every output holds its value, whatever the other inputs do.
- R10: After reset, the outputs are `illegal`=1, `vl`=0, `vlmax`=0, `vtype`=only bit XLEN-1 set, `sew`=1024, `lmul`=8, `mlen`=128, `reg_mask`=(NVREG-1) with its low 3 bits cleared, `vstart`=0 and `op_count`=0.
- R11: `op_count` goes up by one for each accepted request.
- R12: When `new_type` equals the stored `vtype`, `sew`, `lmul`, `mlen`, `reg_mask`, `vlmax` and `illegal` keep their stored values. For example, presenting the top-bit-only word after reset leaves `sew` at 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | One-cycle configuration request strobe |
| cfg_mode | input | 2 | Length source: 0 request, 1 keep, 2 maximum, 3 request |
| req_len | input | XLEN | Requested element count |
| new_type | input | XLEN | New vector type word |
| vl | output | $clog2(VLEN+1) | Granted vector length |
| vlmax | output | $clog2(VLEN+1) | Maximum length for the current type |
| vtype | output | XLEN | Stored type word |
| illegal | output | 1 | Current configuration is unsupported |
| sew | output | 11 | Element width in bits |
| lmul | output | 4 | Register-group multiplier |
| mlen | output | 11 | Mask length (sew / lmul) |
| reg_mask | output | $clog2(NVREG) | Register-group alignment mask |
| vstart | output | $clog2(VLEN+1) | Vector start index |
| op_count | output | CNT_W | Count of configuration requests |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples `cfg_valid`. The decode, the clamp and the counter all feed registers with no further pipeline stage. The bench raises the strobe at a falling edge and drops it at the next falling edge, which lies half a period after the updating edge, and it reads every output at that moment. For the hold cases, the bench changes the inputs with the strobe low over several cycles and reads the outputs again at a falling edge, so an unwanted update would already be visible.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef enum logic [1:0] {
    VL_FROM_REQ = 2'd0,
    VL_KEEP     = 2'd1,
    VL_MAXIMUM  = 2'd2,
    VL_REQ_ALT  = 2'd3
  } vl_mode_e;

  localparam int SEW_W = 11;
  localparam int LMUL_W = 4;
endpackage

// File: rtl/vcfg_type_decode.sv
module vcfg_type_decode
  import vcfg_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int NVREG = 32,
  parameter int VL_W  = $clog2(VLEN + 1),
  parameter int RM_W  = $clog2(NVREG)
) (
  input  logic [XLEN-1:0]   type_word,
  output logic [SEW_W-1:0]  sew,
  output logic [LMUL_W-1:0] lmul,
  output logic [SEW_W-1:0]  mlen,
  output logic [RM_W-1:0]   reg_mask,
  output logic [VL_W-1:0]   vlmax,
  output logic              bad
);
  localparam logic [RM_W-1:0] RM_ALL = RM_W'(NVREG - 1);

  logic [2:0]  sew_code;
  logic [1:0]  lmul_code;
  logic [1:0]  div_code;
  logic [3:0]  sew_shift;
  logic [31:0] scaled;
  logic [31:0] quotient;
  logic        high_set;

  always_comb begin
    sew_code  = type_word[4:2];
    lmul_code = type_word[1:0];
    div_code  = type_word[6:5];
    high_set  = |type_word[XLEN-1:7];
    sew_shift = {1'b0, sew_code} + 4'd3;
    sew       = SEW_W'(1) << sew_shift;
    lmul      = LMUL_W'(1) << lmul_code;
    mlen      = sew >> lmul_code;
    reg_mask  = RM_ALL & ~(RM_W'(lmul) - RM_W'(1));
    bad       = (sew > SEW_W'(ELEN)) || (div_code != 2'd0) || high_set;
    scaled    = 32'(VLEN) << lmul_code;
    quotient  = scaled >> sew_shift;
    vlmax     = bad ? '0 : VL_W'(quotient);
  end
endmodule

// File: rtl/vcfg_len_select.sv
module vcfg_len_select
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VL_W = 8
) (
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] req_len,
  input  logic [VL_W-1:0] old_vl,
  input  logic [VL_W-1:0] vlmax,
  output logic [VL_W-1:0] grant
);
  vl_mode_e sel;

  always_comb begin
    sel = vl_mode_e'(mode);
    if (vlmax == '0) begin
      grant = '0;
    end else begin
      case (sel)
        VL_KEEP:    grant = (old_vl > vlmax) ? vlmax : old_vl;
        VL_MAXIMUM: grant = vlmax;
        default:    grant = (req_len > XLEN'(vlmax)) ? vlmax : VL_W'(req_len);
      endcase
    end
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VLEN  = 128,
  parameter int ELEN  = 64,
  parameter int NVREG = 32,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_valid,
  input  logic [1:0]                 cfg_mode,
  input  logic [XLEN-1:0]            req_len,
  input  logic [XLEN-1:0]            new_type,
  output logic [$clog2(VLEN+1)-1:0]  vl,
  output logic [$clog2(VLEN+1)-1:0]  vlmax,
  output logic [XLEN-1:0]            vtype,
  output logic                       illegal,
  output logic [10:0]                sew,
  output logic [3:0]                 lmul,
  output logic [10:0]                mlen,
  output logic [$clog2(NVREG)-1:0]   reg_mask,
  output logic [$clog2(VLEN+1)-1:0]  vstart,
  output logic [CNT_W-1:0]           op_count
);
  localparam int VL_W = $clog2(VLEN + 1);
  localparam int RM_W = $clog2(NVREG);
  localparam logic [XLEN-1:0]   BAD_TYPE = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [SEW_W-1:0]  RST_SEW  = SEW_W'(1) << 10;
  localparam logic [LMUL_W-1:0] RST_LMUL = LMUL_W'(8);
  localparam logic [RM_W-1:0]   RST_RM   = RM_W'(NVREG - 1) & ~RM_W'(7);

  logic [SEW_W-1:0]  d_sew;
  logic [LMUL_W-1:0] d_lmul;
  logic [SEW_W-1:0]  d_mlen;
  logic [RM_W-1:0]   d_rm;
  logic [VL_W-1:0]   d_vlmax;
  logic              d_bad;
  logic              type_changed;
  logic [VL_W-1:0]   eff_vlmax;
  logic [VL_W-1:0]   grant;

  vcfg_type_decode #(
    .XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .NVREG(NVREG),
    .VL_W(VL_W), .RM_W(RM_W)
  ) u_dec (
    .type_word(new_type),
    .sew(d_sew),
    .lmul(d_lmul),
    .mlen(d_mlen),
    .reg_mask(d_rm),
    .vlmax(d_vlmax),
    .bad(d_bad)
  );

  assign type_changed = (new_type != vtype);
  assign eff_vlmax    = type_changed ? d_vlmax : vlmax;

  vcfg_len_select #(.XLEN(XLEN), .VL_W(VL_W)) u_sel (
    .mode(cfg_mode),
    .req_len(req_len),
    .old_vl(vl),
    .vlmax(eff_vlmax),
    .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vtype    <= BAD_TYPE;
      illegal  <= 1'b1;
      vlmax    <= '0;
      sew      <= RST_SEW;
      lmul     <= RST_LMUL;
      mlen     <= RST_SEW >> 3;
      reg_mask <= RST_RM;
      vl       <= '0;
      vstart   <= '0;
      op_count <= '0;
    end else if (cfg_valid) begin
      if (type_changed) begin
        vtype    <= d_bad ? BAD_TYPE : new_type;
        illegal  <= d_bad;
        vlmax    <= d_vlmax;
        sew      <= d_sew;
        lmul     <= d_lmul;
        mlen     <= d_mlen;
        reg_mask <= d_rm;
      end
      vl       <= grant;
      vstart   <= '0;
      op_count <= op_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN  = 32,
  parameter int VLEN  = 128,
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_valid,
  input logic [1:0]                cfg_mode,
  input logic [XLEN-1:0]           req_len,
  input logic [$clog2(VLEN+1)-1:0] vl,
  input logic [$clog2(VLEN+1)-1:0] vlmax,
  input logic [XLEN-1:0]           vtype,
  input logic                      illegal,
  input logic [CNT_W-1:0]          op_count
);
  localparam int VL_W = $clog2(VLEN + 1);
  localparam logic [XLEN-1:0] BAD_TYPE = {1'b1, {(XLEN-1){1'b0}}};

  assert_illegal_state_R3: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (vlmax == '0 && vtype == BAD_TYPE));

  assert_zero_max_zero_len_R7: assert property (@(posedge clk) disable iff (rst)
    (vlmax == '0) |-> (vl == '0));

  assert_len_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    vl <= vlmax);

  assert_request_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_mode == 2'd0 || cfg_mode == 2'd3)) |=>
      (vl == ((XLEN'(vlmax) < $past(req_len)) ? vlmax : VL_W'($past(req_len)))));

  assert_keep_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_mode == 2'd1) |=>
      (vl == (($past(vl) > vlmax) ? vlmax : $past(vl))));

  assert_force_max_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_mode == 2'd2) |=> (vl == vlmax));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> ($stable(vl) && $stable(vtype) && $stable(vlmax) && $stable(illegal)));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> (op_count == $past(op_count) + CNT_W'(1)));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN(VLEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
  .req_len(req_len), .vl(vl), .vlmax(vlmax), .vtype(vtype),
  .illegal(illegal), .op_count(op_count)
);

// File: tb/sim_vcfg_unit.sv
`timescale 1ns/1ps
module sim_vcfg_unit;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int NVREG = 32;
  localparam int CNT_W = 16;
  localparam int VL_W = $clog2(VLEN + 1);
  localparam int RM_W = $clog2(NVREG);
  localparam logic [31:0] BAD = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [XLEN-1:0] req_len = '0;
  logic [XLEN-1:0] new_type = '0;
  logic [VL_W-1:0] vl, vlmax, vstart;
  logic [XLEN-1:0] vtype;
  logic illegal;
  logic [10:0] sew, mlen;
  logic [3:0] lmul;
  logic [RM_W-1:0] reg_mask;
  logic [CNT_W-1:0] op_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .NVREG(NVREG), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
    .req_len(req_len), .new_type(new_type), .vl(vl), .vlmax(vlmax),
    .vtype(vtype), .illegal(illegal), .sew(sew), .lmul(lmul), .mlen(mlen),
    .reg_mask(reg_mask), .vstart(vstart), .op_count(op_count)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [31:0] r, input logic [31:0] t);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_mode = m; req_len = r; new_type = t;
    @(negedge clk);
    cfg_valid = 1'b0;
    exp_cnt++;
  endtask

  task automatic t_reset;
    chk("R10", "illegal", 64'(illegal), 1);
    chk("R10", "vl", 64'(vl), 0);
    chk("R10", "vlmax", 64'(vlmax), 0);
    chk("R10", "vtype", 64'(vtype), 64'(BAD));
    chk("R10", "sew", 64'(sew), 1024);
    chk("R10", "lmul", 64'(lmul), 8);
    chk("R10", "mlen", 64'(mlen), 128);
    chk("R10", "reg_mask", 64'(reg_mask), 24);
    chk("R10", "vstart", 64'(vstart), 0);
    chk("R10", "op_count", 64'(op_count), 0);
  endtask

  task automatic t_same_type;
    apply(2'd0, 32'd5, BAD);
    chk("R12", "sew kept", 64'(sew), 1024);
    chk("R12", "lmul kept", 64'(lmul), 8);
    chk("R12", "illegal kept", 64'(illegal), 1);
    chk("R7", "vl zero", 64'(vl), 0);
  endtask

  task automatic t_request;
    apply(2'd0, 32'd5, 32'h09);
    chk("R1", "sew", 64'(sew), 32);
    chk("R1", "lmul", 64'(lmul), 2);
    chk("R1", "mlen", 64'(mlen), 16);
    chk("R1", "reg_mask", 64'(reg_mask), 30);
    chk("R2", "vlmax", 64'(vlmax), 8);
    chk("R3", "legal", 64'(illegal), 0);
    chk("R4", "vl below max", 64'(vl), 5);
    chk("R8", "vtype stored", 64'(vtype), 64'h09);
    chk("R8", "vstart", 64'(vstart), 0);
    apply(2'd0, 32'd20, 32'h09);
    chk("R4", "vl clamped", 64'(vl), 8);
    apply(2'd0, 32'd8, 32'h09);
    chk("R4", "vl at max", 64'(vl), 8);
    apply(2'd0, 32'hFFFF_FFFF, 32'h09);
    chk("R4", "vl huge request", 64'(vl), 8);
    apply(2'd0, 32'd0, 32'h09);
    chk("R4", "vl zero request", 64'(vl), 0);
  endtask

  task automatic t_keep;
    apply(2'd0, 32'd8, 32'h09);
    apply(2'd1, 32'd3, 32'h00);
    chk("R2", "vlmax sew8", 64'(vlmax), 16);
    chk("R5", "keep vl", 64'(vl), 8);
    apply(2'd1, 32'd99, 32'h0C);
    chk("R2", "vlmax sew64", 64'(vlmax), 2);
    chk("R1", "mlen sew64", 64'(mlen), 64);
    chk("R1", "reg_mask lmul1", 64'(reg_mask), 31);
    chk("R5", "keep clamped", 64'(vl), 2);
    apply(2'd1, 32'd0, 32'h03);
    chk("R1", "reg_mask lmul8", 64'(reg_mask), 24);
    chk("R1", "mlen lmul8", 64'(mlen), 1);
    chk("R5", "keep grown max", 64'(vl), 2);
  endtask

  task automatic t_max;
    apply(2'd2, 32'd1, 32'h03);
    chk("R6", "force max", 64'(vl), 128);
    apply(2'd3, 32'd7, 32'h03);
    chk("R6", "mode3 as request", 64'(vl), 7);
  endtask

  task automatic t_hold;
    @(negedge clk);
    cfg_mode = 2'd2; req_len = 32'd50; new_type = 32'h10;
    repeat (5) @(negedge clk);
    chk("R9", "vl held", 64'(vl), 7);
    chk("R9", "vtype held", 64'(vtype), 64'h03);
    chk("R9", "vlmax held", 64'(vlmax), 128);
    chk("R9", "count held", 64'(op_count), 64'(exp_cnt));
  endtask

  task automatic t_illegal;
    apply(2'd2, 32'd5, 32'h10);
    chk("R3", "wide sew illegal", 64'(illegal), 1);
    chk("R3", "vlmax zero", 64'(vlmax), 0);
    chk("R3", "vtype top bit", 64'(vtype), 64'(BAD));
    chk("R3", "sew stored", 64'(sew), 128);
    chk("R7", "max mode zero", 64'(vl), 0);
    apply(2'd0, 32'd4, 32'h09);
    chk("R4", "recovered", 64'(vl), 4);
    apply(2'd2, 32'd5, 32'h20);
    chk("R3", "divide field illegal", 64'(illegal), 1);
    chk("R7", "divide vl zero", 64'(vl), 0);
    apply(2'd0, 32'd3, 32'h09);
    chk("R4", "recovered again", 64'(vl), 3);
    apply(2'd1, 32'd0, 32'h80);
    chk("R3", "high bit illegal", 64'(illegal), 1);
    chk("R3", "high bit vtype", 64'(vtype), 64'(BAD));
    chk("R7", "keep mode zero", 64'(vl), 0);
    chk("R8", "vstart", 64'(vstart), 0);
  endtask

  task automatic t_count;
    chk("R11", "op_count", 64'(op_count), 64'(exp_cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_same_type();
    t_request();
    t_keep();
    t_max();
    t_hold();
    t_illegal();
    t_count();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all R): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule